// File: doc/BRIEF.md
# Prescaled Two-Channel Pulse-Width Modulator

This block produces one or two pulse-width modulated outputs from a single fast clock. Each channel first divides the clock through a prescaler. The prescaler divisor is chosen from a fixed, sparse table of ratios, and one code passes the clock through undivided. The channel then counts prescaled ticks across a programmable period and drives its output to the active level for a programmable number of ticks at the start of each period. A per-channel bit sets the output polarity.

Software reaches the block through a simple synchronous register bus with write strobe, byte address, write data and combinational read data. One control word holds a ten-bit field group for every channel. The field groups sit 15 bits apart, and read-only busy flags sit above them. Each channel also has its own word that combines period and duty.

A period/duty write does not touch the running waveform directly. It lands in a shadow copy and raises the channel's busy flag. The shadow value becomes live at the boundary of the current period, or straight away when the channel is stopped, so a running waveform never shows a torn period.

Top module: `pwm_duo`

## Requirements
- R1: After reset every register reads zero, no busy flag is set, and every output is high. High is the inactive level when the active-level bit is 0.
- R2: The control word (byte address 0x0) holds one field group for channel n starting at bit 15*n. Within a group, bits [3:0] are the prescaler code, bit 4 is enable, bit 5 is active level, bit 6 is clock gate, bit 7 is mode, bit 8 is pulse start and bit 9 is bypass. These fields are stored and read back. Bits 10 to 14 of each group, and every unused bit, read zero.
- R3: A channel runs only while both its enable bit and its clock-gate bit are 1. Otherwise its output sits at the inactive level, and its prescaler and period counter are held at zero, so a restart begins at the start of a period.
- R4: Prescaler codes 0 to 4 divide the clock by 120, 180, 240, 360 and 480. Codes 8 to 12 divide it by 12000, 24000, 36000, 48000 and 72000. Code 15 divides by 1. Any other code is stored but produces no ticks, so the period counter stops.
- R5: The period/duty word of channel n is at byte address 0x4+4*n. Bits [31:16] hold the period in prescaled ticks minus one, and bits [15:0] hold the duty in ticks. The output is active for the first duty ticks of each period. The active level is high when the active-level bit is 1 and low when it is 0.
- R6: A duty of 0 keeps the output inactive throughout. A duty greater than the period-minus-one field keeps it active throughout.
- R7: A period/duty write is stored in a shadow word, which is what the register reads back. It also sets the channel's busy flag at control bit 28+n from the next cycle on.
- R8: While the channel runs, the shadow word becomes live on the tick that ends the current period, and the busy flag clears at that same edge. A write accepted on the period-ending cycle waits for the following period end.
- R9: While the channel is stopped, a pending shadow word becomes live at the next clock edge, and the busy flag clears.
- R10: A period/duty write that arrives while the channel's busy flag is set is ignored.
- R11: With NUM_CH set to 1, the channel-1 period/duty register, the channel-1 control fields and busy bit 29 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Combinational read data for `addr` |
| pwm_out | output | NUM_CH | Modulated output, one bit per channel |

## Verification
The period-boundary reload and a fresh period/duty write can fall in the same cycle. The bench provokes this on a running channel with a four-tick period, using a duty of one to locate the phase. It times a write so that the write is captured on the exact edge where the count wraps. The expected outcome is that the busy flag stays set for the whole next period and clears exactly four edges later. A second write issued during that window must leave the read-back word unchanged, and the new duty must then appear in the output.

// File: rtl/pwm_duo_pkg.sv
// Shared constants, control-field type and divisor decode for the PWM block.
// Assumes the control word is 32 bits and at most two channels exist.
package pwm_duo_pkg;
    localparam int GRP_STRIDE = 15;   // bit distance between channel groups
    localparam int GRP_W      = 10;   // stored bits per channel group
    localparam int BUSY_BASE  = 28;   // busy flag of channel 0
    localparam int PRD_W      = 16;   // period and duty field width
    localparam int PRE_W      = 17;   // prescaler counter width (covers 72000)

    // One channel's control group, bit 0 is the prescaler code LSB.
    typedef struct packed {
        logic       bypass;
        logic       pulse;
        logic       mode;
        logic       gate;
        logic       act_hi;
        logic       enable;
        logic [3:0] psel;
    } ch_ctrl_t;

    // Divisor for a prescaler code; zero marks a reserved code.
    function automatic logic [PRE_W-1:0] presc_div(input logic [3:0] code);
        case (code)
            4'd0:    return PRE_W'(120);
            4'd1:    return PRE_W'(180);
            4'd2:    return PRE_W'(240);
            4'd3:    return PRE_W'(360);
            4'd4:    return PRE_W'(480);
            4'd8:    return PRE_W'(12000);
            4'd9:    return PRE_W'(24000);
            4'd10:   return PRE_W'(36000);
            4'd11:   return PRE_W'(48000);
            4'd12:   return PRE_W'(72000);
            4'd15:   return PRE_W'(1);
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/pwm_prescaler.sv
// Clock divider for one channel: emits a one-cycle tick every N input
// cycles, N taken from the code table. Assumes run is already the AND of
// enable and gate; a reserved code or a stopped channel yields no ticks.
module pwm_prescaler
    import pwm_duo_pkg::*;
#(
    parameter int CNT_W = PRE_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [3:0] code,
    output logic       tick
);
    logic [PRE_W-1:0] div;
    logic [CNT_W-1:0] cnt_q;
    logic             resv;
    logic             at_top;

    assign div    = presc_div(code);
    assign resv   = (div == '0);
    assign at_top = (cnt_q == CNT_W'(div - PRE_W'(1)));
    assign tick   = run && !resv && at_top;

    // Divider count: cleared when stopped or reserved, wraps at divisor-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || resv || at_top) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/pwm_channel.sv
// One modulator channel: shadow period/duty word with busy flag, live
// period/duty, tick-driven period counter and duty compare. Assumes wr_pd
// is a one-cycle strobe and tick comes from this channel's prescaler.
module pwm_channel
    import pwm_duo_pkg::*;
#(
    parameter int CW = PRD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          act_hi,
    input  logic          tick,
    input  logic          wr_pd,
    input  logic [31:0]   wdata,
    output logic [31:0]   shadow_o,
    output logic          busy_o,
    output logic [CW-1:0] phase_o,
    output logic          pwm_o
);
    logic [31:0]   shadow_q;
    logic          busy_q;
    logic [CW-1:0] live_prd_q;
    logic [CW-1:0] live_dty_q;
    logic [CW-1:0] pcnt_q;
    logic          prd_end;
    logic          load;
    logic          accept;

    assign prd_end = tick && (pcnt_q == live_prd_q);
    assign load    = busy_q && (!run || prd_end);
    assign accept  = wr_pd && !busy_q;

    // Shadow word: takes a write only when no update is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (accept) begin
            shadow_q <= wdata;
        end
    end

    // Busy flag: set by an accepted write, cleared when the shadow goes live.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (load) begin
            busy_q <= 1'b0;
        end else if (accept) begin
            busy_q <= 1'b1;
        end
    end

    // Live period/duty: copied from the shadow at a boundary or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_prd_q <= '0;
            live_dty_q <= '0;
        end else if (load) begin
            live_prd_q <= shadow_q[16 +: CW];
            live_dty_q <= shadow_q[0 +: CW];
        end
    end

    // Period counter: held at zero when stopped, wraps after the period field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (!run || prd_end) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= pcnt_q + CW'(1);
        end
    end

    assign pwm_o    = (run && (pcnt_q < live_dty_q)) ? act_hi : !act_hi;
    assign shadow_o = shadow_q;
    assign busy_o   = busy_q;
    assign phase_o  = pcnt_q;
endmodule

// File: rtl/pwm_duo.sv
// Register front end and channel array of the PWM block. Decodes the
// control word (groups at a 15-bit stride, busy flags from bit 28) and the
// per-channel period/duty words at 0x4+4n. Assumes NUM_CH is 1 or 2 and a
// synchronous bus with single-cycle writes; reads are combinational.
module pwm_duo
    import pwm_duo_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0]       word;
    logic                    unused_lsb;
    logic                    wr_ctrl;
    logic [NUM_CH*GRP_W-1:0] ch_fields;
    logic [NUM_CH*32-1:0]    ch_shadow;
    logic [NUM_CH*PRD_W-1:0] ch_phase;
    logic [NUM_CH-1:0]       ch_run;
    logic [NUM_CH-1:0]       ch_act;
    logic [NUM_CH-1:0]       ch_tick;
    logic [NUM_CH-1:0]       ch_busy;
    logic [NUM_CH-1:0]       ch_resv;
    logic [31:0]             rd_ctrl;

    assign word       = addr[ADDR_W-1:2];
    assign unused_lsb = ^addr[1:0];
    assign wr_ctrl    = wr_en && (word == '0);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        ch_ctrl_t grp_q;
        logic     wr_pd;

        assign wr_pd = wr_en && (word == WORD_W'(n + 1));

        // Control group of this channel: loaded from its slice of the word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                grp_q <= '0;
            end else if (wr_ctrl) begin
                grp_q <= ch_ctrl_t'(wdata[n*GRP_STRIDE +: GRP_W]);
            end
        end

        assign ch_fields[n*GRP_W +: GRP_W] = grp_q;
        assign ch_run[n]  = grp_q.enable && grp_q.gate;
        assign ch_act[n]  = grp_q.act_hi;
        assign ch_resv[n] = (presc_div(grp_q.psel) == '0);

        pwm_prescaler #(.CNT_W(PRE_W)) u_pre (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (ch_run[n]),
            .code (grp_q.psel),
            .tick (ch_tick[n])
        );

        pwm_channel #(.CW(PRD_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (ch_run[n]),
            .act_hi  (grp_q.act_hi),
            .tick    (ch_tick[n]),
            .wr_pd   (wr_pd),
            .wdata   (wdata),
            .shadow_o(ch_shadow[n*32 +: 32]),
            .busy_o  (ch_busy[n]),
            .phase_o (ch_phase[n*PRD_W +: PRD_W]),
            .pwm_o   (pwm_out[n])
        );
    end

    // Control word image: field groups plus read-only busy flags.
    always_comb begin
        rd_ctrl = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            rd_ctrl[n*GRP_STRIDE +: GRP_W] = ch_fields[n*GRP_W +: GRP_W];
            rd_ctrl[BUSY_BASE + n]         = ch_busy[n];
        end
    end

    // Read mux: control word, shadow words of present channels, else zero.
    always_comb begin
        rdata = '0;
        if (word == '0) begin
            rdata = rd_ctrl;
        end else begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (word == WORD_W'(n + 1)) begin
                    rdata = ch_shadow[n*32 +: 32];
                end
            end
        end
    end
endmodule

// File: rtl/pwm_duo_chk.sv
// Property checker for pwm_duo, attached by bind. Observes the bus, the
// per-channel run/level/tick/busy/phase nets and the outputs.
module pwm_duo_chk #(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4,
    parameter int PW     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [NUM_CH-1:0] ch_run,
    input logic [NUM_CH-1:0] ch_act,
    input logic [NUM_CH-1:0] ch_tick,
    input logic [NUM_CH-1:0] ch_busy,
    input logic [NUM_CH-1:0] ch_resv,
    input logic [NUM_CH*PW-1:0] ch_phase,
    input logic [NUM_CH-1:0] pwm_out
);
    for (genvar n = 0; n < NUM_CH; n++) begin : g_prop
        // R3: a stopped channel shows its inactive level
        assert_stop_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_run[n] |-> (pwm_out[n] == !ch_act[n]));
        // R3: a stopped channel has its period counter at zero
        assert_stop_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_run[n] |=> (ch_phase[n*PW +: PW] == '0));
        // R4: a reserved code produces no ticks
        assert_resv_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ch_resv[n] |-> !ch_tick[n]);
        // R7: busy only rises after a write to this channel's word
        assert_busy_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_busy[n]) |-> $past(wr_en && (addr[ADDR_W-1:2] == (ADDR_W-2)'(n + 1))));
        // R9: pending update on a stopped channel clears next cycle
        assert_idle_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_busy[n] && !ch_run[n]) |=> !ch_busy[n]);
    end
endmodule

bind pwm_duo pwm_duo_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .PW(pwm_duo_pkg::PRD_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .ch_run  (ch_run),
    .ch_act  (ch_act),
    .ch_tick (ch_tick),
    .ch_busy (ch_busy),
    .ch_resv (ch_resv),
    .ch_phase(ch_phase),
    .pwm_out (pwm_out)
);

// File: tb/pwm_duo_tb.sv
`timescale 1ns/1ps
// Bench: table of waveform vectors walked by one loop, then directed tests
// for reset, register layout, the update handshake and the 1-channel build.
module pwm_duo_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] rdata1;
    logic [1:0]  pwm_out;
    logic [0:0]  pwm_out1;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    pwm_duo #(.NUM_CH(2), .ADDR_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

    pwm_duo #(.NUM_CH(1), .ADDR_W(4)) dut1_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata1), .pwm_out(pwm_out1));

    typedef struct packed {
        logic        ch;
        logic [15:0] prd;
        logic [15:0] dty;
        logic        act;
        logic [3:0]  code;
        int          win;
        int          exp_hi;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b0, 16'd3, 16'd1, 1'b1, 4'd15, 16,    4},     // R5 quarter duty
        '{1'b0, 16'd3, 16'd0, 1'b1, 4'd15, 16,    0},     // R6 zero duty
        '{1'b0, 16'd3, 16'd4, 1'b1, 4'd15, 16,    16},    // R6 duty above period
        '{1'b0, 16'd3, 16'd2, 1'b0, 4'd15, 16,    8},     // R5 active-low
        '{1'b1, 16'd3, 16'd3, 1'b1, 4'd15, 16,    12},    // R5 channel 1
        '{1'b0, 16'd3, 16'd1, 1'b1, 4'd0,  480,   120},   // R4 divide 120
        '{1'b0, 16'd1, 16'd1, 1'b1, 4'd3,  720,   360},   // R4 divide 360
        '{1'b1, 16'd1, 16'd1, 1'b1, 4'd8,  24000, 12000}, // R4 divide 12000
        '{1'b0, 16'd3, 16'd1, 1'b1, 4'd5,  16,    16}     // R4 reserved code
    };

    function automatic logic [31:0] cw(int ch, logic [3:0] code, logic en, logic act, logic gate);
        logic [31:0] w = '0;
        w[ch*15 +: 10] = {3'b000, gate, act, en, code};
        return w;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d, output logic [31:0] d1);
        addr = a;
        #1;
        d = rdata; d1 = rdata1;
        addr = '0;
    endtask

    task automatic count_hi(int ch, int win, output int hi);
        hi = 0;
        for (int i = 0; i < win; i++) begin
            if (pwm_out[ch]) hi++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, d1;
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, d, d1); check("R1 ctrl", d, 32'h0); check("R1 ctrl 1ch", d1, 32'h0);
        rd(4'h4, d, d1); check("R1 pd0", d, 32'h0);
        rd(4'h8, d, d1); check("R1 pd1", d, 32'h0);
        check("R1 outputs", {30'd0, pwm_out}, 32'h3);
        check("R1 output 1ch", {31'd0, pwm_out1}, 32'h1);

        // R2 field layout and read-back, R11 for the single-channel build
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, d, d1);
        check("R2 ctrl readback", d, 32'h01FF_83FF);
        check("R11 ctrl 1ch", d1 & 32'hEFFF_FFFF, 32'h0000_03FF);
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h8, d, d1);
        check("R11 pd1 absent", d1, 32'h0);
        check("R7 pd1 shadow", d, 32'hFFFF_FFFF);
        rd(4'hC, d, d1);
        check("R2 unmapped", d, 32'h0);
        wr(4'h0, 32'h0);
        @(negedge clk);

        // Table walk: R4 R5 R6
        for (int v = 0; v < 9; v++) begin
            wr(4'h0, 32'h0);
            wr(VECS[v].ch ? 4'h8 : 4'h4, {VECS[v].prd, VECS[v].dty});
            wr(4'h0, 32'h0);
            wr(4'h0, cw(int'(VECS[v].ch), VECS[v].code, 1'b1, VECS[v].act, 1'b1));
            count_hi(int'(VECS[v].ch), VECS[v].win, hi);
            check($sformatf("R4/R5/R6 vector %0d high count", v), hi, VECS[v].exp_hi);
        end

        // R3 gate cleared stops output at inactive level, restart at phase 0
        wr(4'h0, 32'h0);
        wr(4'h4, {16'd3, 16'd1});
        wr(4'h0, 32'h0);
        wr(4'h0, cw(0, 4'd15, 1'b1, 1'b1, 1'b1));
        repeat (2) @(negedge clk);
        wr(4'h0, cw(0, 4'd15, 1'b1, 1'b1, 1'b0));
        count_hi(0, 10, hi);
        check("R3 gate off holds inactive", hi, 0);
        wr(4'h0, cw(0, 4'd15, 1'b1, 1'b1, 1'b1));
        check("R3 restart at period start", {31'd0, pwm_out[0]}, 32'h1);

        // R7 R8 R10: write captured on the period-ending edge
        @(negedge clk);
        while (!pwm_out[0]) @(negedge clk);
        repeat (3) @(negedge clk);
        wr(4'h4, {16'd7, 16'd4});
        rd(4'h0, d, d1); check("R7 busy set", d[28], 1'b1);
        rd(4'h4, d, d1); check("R7 shadow readback", d, 32'h0007_0004);
        wr(4'h4, 32'h0001_0001);
        rd(4'h4, d, d1); check("R10 write while busy ignored", d, 32'h0007_0004);
        repeat (2) @(negedge clk);
        rd(4'h0, d, d1); check("R8 busy held through next period", d[28], 1'b1);
        @(negedge clk);
        rd(4'h0, d, d1); check("R8 busy cleared at period end", d[28], 1'b0);
        count_hi(0, 8, hi);
        check("R8 new duty live", hi, 4);

        // R8 R9: slow period keeps busy; stopping the channel loads at once
        wr(4'h0, 32'h0);
        wr(4'h4, {16'd3, 16'd1});
        wr(4'h0, 32'h0);
        wr(4'h0, cw(0, 4'd0, 1'b1, 1'b1, 1'b1));
        wr(4'h4, {16'd5, 16'd2});
        repeat (50) @(negedge clk);
        rd(4'h0, d, d1); check("R8 busy until period end", d[28], 1'b1);
        wr(4'h0, 32'h0);
        rd(4'h0, d, d1); check("R9 busy before idle load", d[28], 1'b1);
        @(negedge clk);
        rd(4'h0, d, d1); check("R9 busy cleared when stopped", d[28], 1'b0);
        rd(4'h4, d, d1); check("R9 shadow kept", d, 32'h0005_0002);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule